// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block supervises a processor and drives its reset. It has four reset sources. The first is power-on, which the block's own asynchronous reset stands for. The second is a debounced pushbutton. The third is a supply-low flag that comes from an external comparator. The fourth is a watchdog that cannot be turned off.

Every source feeds one shared extension counter. Reset therefore stays active for a fixed number of clock ticks after the last cause goes away. Every duration is a tick-count parameter.

Reset leaves the block in two forms at once:
- an active-high level;
- an active-low, open-drain-style pair made of a drive enable and a driven value of zero.

After reset releases, software must produce a falling edge on the strobe input before the selected watchdog period runs out. If it does not, the block starts a new reset pulse. A tolerance select is not used inside the block; it is passed straight through to the comparator.

Top module: `supervisor_rst_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rst_o` is 1. After `rst_ni` rises, `rst_o` stays 1 for exactly EXT_TICKS clock edges and then falls.
- R2: `rst_n_oe_o` always equals `rst_o`, and `rst_n_o` is always 0. The active-low line is therefore pulled low only while reset is active and is released otherwise.
- R3: The pushbutton input (`pb_ni`, low = pressed) passes through a two-flop synchroniser. It must then read low on DEB_TICKS consecutive edges before it counts as a press, so reset rises DEB_TICKS+3 edges after `pb_ni` falls. A low lasting DEB_TICKS-1 cycles has no effect.
- R4: After the button is released, reset falls EXT_TICKS+3 edges after `pb_ni` rises. A release bounce shorter than DEB_TICKS does not start a second pulse.
- R5: On the edge after `pwr_low_i` is 1, `rst_o` is 1. Reset falls EXT_TICKS edges after the last edge at which `pwr_low_i` was seen high, so a re-assertion during the extension restarts the full extension.
- R6: The watchdog counter is held at zero while reset is active. If no strobe edge arrives, reset rises WDG_SHORT/MID/LONG edges after reset falls. The watchdog has no disable path.
- R7: Only a falling edge of `wdg_strobe_ni` clears the watchdog, and it does so 3 edges after the input falls, counting the synchroniser. A strobe held at a constant level does not service it.
- R8: `tmo_sel_i` selects the watchdog period: 2'b00 gives WDG_SHORT, 2'b01 gives WDG_MID, and 2'b10 or 2'b11 give WDG_LONG (default ratio 1:4:8).
- R9: A watchdog expiry produces a normal EXT_TICKS reset pulse. After that pulse the watchdog counts again from zero and expires WDG period edges after the fall if it is not strobed.
- R10: `tol_sel_o` follows `tol_sel_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, models power-on |
| pwr_low_i | input | 1 | Synchronous supply-low flag from comparator |
| tol_sel_i | input | 1 | Trip tolerance select (0: 5 %, 1: 10 %) |
| tol_sel_o | output | 1 | Tolerance select routed to comparator |
| pb_ni | input | 1 | Pushbutton, low when pressed |
| wdg_strobe_ni | input | 1 | Watchdog strobe, serviced by falling edge |
| tmo_sel_i | input | 2 | Watchdog period select |
| rst_o | output | 1 | Active-high reset |
| rst_n_oe_o | output | 1 | Drive enable of the active-low reset |
| rst_n_o | output | 1 | Driven value of the active-low reset (always 0) |

## Verification
The bench predicts the exact cycle of every rise and fall of reset and compares it with the observed edges:
- **Supply-low:** a long low and a re-assertion inside the extension show whether the extension restarts from the last cause.
- **Pushbutton:** a held press with a bounce on release, and a glitch one tick shorter than the debounce window, separate a real press from noise and expose any re-triggering.
- **Watchdog:** runs with no strobe, with the strobe held low, and with each period select (including the alias code) separate edge-based servicing from level-based servicing. They also expose a wrong period or a counter that fails to restart after its own pulse.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    TMO_SHORT = 2'b00,
    TMO_MID   = 2'b01,
    TMO_LONG  = 2'b10,
    TMO_LONG2 = 2'b11
  } tmo_sel_e;
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int unsigned DEB_TICKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic press_o
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          press_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else if (btn_ni) begin
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else if (!press_q) begin
      if (cnt_q == CW'(DEB_TICKS - 1)) press_q <= 1'b1;
      else                             cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign press_o = press_q;

  // a high sample always drops the press
  assert_release_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_ni |=> !press_q);
  // no press before the stable-low window has filled
  assert_short_low_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!press_q && cnt_q < CW'(DEB_TICKS - 1)) |=> !press_q);
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int unsigned WDG_SHORT = 80,
  parameter int unsigned WDG_MID   = 320,
  parameter int unsigned WDG_LONG  = 640
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       strobe_ni,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int unsigned CW = $clog2(WDG_LONG + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          prev_q, fall;

  always_comb begin
    unique case (tmo_sel_e'(sel_i))
      TMO_SHORT: lim = CW'(WDG_SHORT);
      TMO_MID:   lim = CW'(WDG_MID);
      default:   lim = CW'(WDG_LONG);
    endcase
  end

  assign fall     = prev_q & ~strobe_ni;
  // >= so a period shortened mid-count still expires
  assign expire_o = !hold_i && !fall && (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= strobe_ni;
      if (hold_i || fall) cnt_q <= '0;
      else if (!expire_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_held_in_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  assert_fall_restarts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !hold_i) |=> (cnt_q == '0));
  assert_level_no_service_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_ni == prev_q && !hold_i && !expire_o) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int unsigned EXT_TICKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(EXT_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (cause_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (cnt_q == CW'(EXT_TICKS - 1)) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;

  assert_cause_forces_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> rst_q);
  assert_full_extension_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && !cause_i && cnt_q != CW'(EXT_TICKS - 1)) |=> rst_q);
endmodule

// File: rtl/supervisor_rst_ctrl.sv
module supervisor_rst_ctrl #(
  parameter int unsigned EXT_TICKS = 40,
  parameter int unsigned DEB_TICKS = 6,
  parameter int unsigned WDG_SHORT = 80,
  parameter int unsigned WDG_MID   = 320,
  parameter int unsigned WDG_LONG  = 640
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_low_i,
  input  logic       tol_sel_i,
  output logic       tol_sel_o,
  input  logic       pb_ni,
  input  logic       wdg_strobe_ni,
  input  logic [1:0] tmo_sel_i,
  output logic       rst_o,
  output logic       rst_n_oe_o,
  output logic       rst_n_o
);
  logic [1:0] sync_q;
  logic       press, expire, cause, rst_q;

  supv_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pb_ni, wdg_strobe_ni}),
    .q_o   (sync_q)
  );

  supv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_ni (sync_q[1]),
    .press_o(press)
  );

  supv_watchdog #(
    .WDG_SHORT(WDG_SHORT),
    .WDG_MID  (WDG_MID),
    .WDG_LONG (WDG_LONG)
  ) u_wdg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (rst_q),
    .strobe_ni(sync_q[0]),
    .sel_i    (tmo_sel_i),
    .expire_o (expire)
  );

  assign cause = pwr_low_i | press | expire;

  supv_stretch #(.EXT_TICKS(EXT_TICKS)) u_str (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(cause),
    .rst_o  (rst_q)
  );

  assign rst_o      = rst_q;
  assign rst_n_oe_o = rst_q;
  assign rst_n_o    = 1'b0;
  assign tol_sel_o  = tol_sel_i;

  assert_supply_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_low_i |=> rst_o);
  assert_press_resets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> rst_o);
  assert_expiry_resets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> rst_o);
endmodule

// File: tb/supervisor_rst_ctrl_tb_top.sv
module supervisor_rst_ctrl_tb_top;
  localparam int EXT = 40;
  localparam int DEB = 6;
  localparam int WS  = 80;
  localparam int WM  = 320;
  localparam int WL  = 640;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni, pwr_low, tol_i, pb_n, stb_n;
  logic [1:0] sel;
  logic tol_o, rst_o, oe_o, rn_o;

  supervisor_rst_ctrl #(
    .EXT_TICKS(EXT), .DEB_TICKS(DEB),
    .WDG_SHORT(WS), .WDG_MID(WM), .WDG_LONG(WL)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_low_i(pwr_low),
    .tol_sel_i(tol_i), .tol_sel_o(tol_o), .pb_ni(pb_n),
    .wdg_strobe_ni(stb_n), .tmo_sel_i(sel),
    .rst_o(rst_o), .rst_n_oe_o(oe_o), .rst_n_o(rn_o)
  );

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {logic lvl; int at; string tag;} ev_t;
  ev_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  bit mon_prev = 1'b1;
  bit strobing = 1'b0;
  bit done = 1'b0;
  int s_last = -1000;
  int f_last = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(logic lvl, int at, string tag);
    ev_t e;
    e.lvl = lvl; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: every reset edge is popped and compared
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && rst_o !== mon_prev) begin
      mon_prev = rst_o;
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected reset edge R3/R6", cyc, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.lvl == rst_o && e.at == cyc, e.tag, cyc, e.at);
      end
      chk(oe_o === rst_o && rn_o === 1'b0, "R2 open-drain pair", int'(oe_o), int'(rst_o));
    end
  end

  task automatic tick();
    @(negedge clk_i);
    if (strobing) begin
      if (cyc - s_last >= 20) begin
        stb_n  = 1'b0;
        s_last = cyc;
      end else if (cyc - s_last == 3) begin
        stb_n = 1'b1;
      end
    end
  endtask

  task automatic ticks(int n);
    repeat (n) tick();
  endtask

  task automatic stop_strobe();
    strobing = 1'b0;
    if (stb_n == 1'b0) begin
      @(negedge clk_i);
      stb_n = 1'b1;
    end
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic sel_test(logic [1:0] s, int lim);
    int c, d, r;
    pwr_low = 1'b1; c = cyc;
    expect_ev(1'b1, c + 1, "R8 supply pulse rise");
    sel = s;
    ticks(5);
    pwr_low = 1'b0; d = cyc;
    expect_ev(1'b0, d + EXT, "R8 supply pulse fall");
    stop_strobe();
    r = mx(d + EXT, s_last + 3) + lim;
    expect_ev(1'b1, r, "R8 period expiry rise");
    expect_ev(1'b0, r + EXT, "R8 expiry pulse fall");
    f_last = r + EXT;
    while (cyc < r + EXT + 2) tick();
    strobing = 1'b1;
    ticks(40);
  endtask

  initial begin
    int c, d, r;
    rst_ni = 1'b0; pwr_low = 1'b0; tol_i = 1'b0; pb_n = 1'b1; stb_n = 1'b1; sel = 2'b00;
    ticks(3);
    chk(rst_o === 1'b1, "R1 reset state", int'(rst_o), 1);
    chk(oe_o === 1'b1 && rn_o === 1'b0, "R2 reset state", int'(oe_o), 1);
    tol_i = 1'b1; tick();
    chk(tol_o === 1'b1, "R10 pass high", int'(tol_o), 1);
    tol_i = 1'b0; tick();
    chk(tol_o === 1'b0, "R10 pass low", int'(tol_o), 0);

    // power-on release
    rst_ni = 1'b1; c = cyc;
    expect_ev(1'b0, c + EXT, "R1 power-on extension");
    f_last = c + EXT;
    strobing = 1'b1;
    ticks(EXT + 200);
    chk(rst_o === 1'b0, "R6 serviced watchdog stays quiet", int'(rst_o), 0);

    // watchdog expiry, then restart with no strobe
    stop_strobe();
    r = mx(f_last, s_last + 3) + WS;
    expect_ev(1'b1, r, "R6 expiry rise");
    expect_ev(1'b0, r + EXT, "R9 expiry pulse fall");
    f_last = r + EXT;
    expect_ev(1'b1, f_last + WS, "R9 restart from zero rise");
    expect_ev(1'b0, f_last + WS + EXT, "R9 second pulse fall");
    f_last = f_last + WS + EXT;
    while (cyc < f_last + 2) tick();
    strobing = 1'b1;
    ticks(100);

    // strobe held low: one edge only
    stop_strobe();
    tick(); tick();
    stb_n = 1'b0; s_last = cyc;
    r = mx(f_last, s_last + 3) + WS;
    expect_ev(1'b1, r, "R7 constant level expiry rise");
    expect_ev(1'b0, r + EXT, "R7 constant level pulse fall");
    f_last = r + EXT;
    while (cyc < f_last + 2) tick();
    stb_n = 1'b1;
    strobing = 1'b1;
    ticks(60);

    // supply low with re-assertion inside the extension
    pwr_low = 1'b1; c = cyc;
    expect_ev(1'b1, c + 1, "R5 supply low rise");
    ticks(30);
    pwr_low = 1'b0;
    ticks(10);
    pwr_low = 1'b1;
    ticks(4);
    pwr_low = 1'b0; d = cyc;
    expect_ev(1'b0, d + EXT, "R5 extension after last low");
    f_last = d + EXT;
    ticks(EXT + 30);

    // pushbutton press with release bounce
    pb_n = 1'b0; c = cyc;
    expect_ev(1'b1, c + 3 + DEB, "R3 debounced press rise");
    ticks(25);
    pb_n = 1'b1; d = cyc;
    expect_ev(1'b0, d + 3 + EXT, "R4 release extension fall");
    ticks(5);
    pb_n = 1'b0;
    ticks(2);
    pb_n = 1'b1;
    f_last = d + 3 + EXT;
    ticks(EXT + 30);

    // glitch one tick short of the debounce window
    pb_n = 1'b0;
    ticks(DEB - 1);
    pb_n = 1'b1;
    ticks(20);
    chk(rst_o === 1'b0, "R3 short press ignored", int'(rst_o), 0);

    sel_test(2'b01, WM);
    sel_test(2'b10, WL);
    sel_test(2'b11, WL);
    sel_test(2'b00, WS);

    ticks(20);
    while (exp_q.size() != 0) begin
      ev_t e;
      e = exp_q.pop_front();
      chk(1'b0, e.tag, -1, e.at);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule